// File: doc/BRIEF.md
# Ethernet Timestamp Capture Queue

This block records when precision-time frames pass one direction (transmit or receive) of a byte-wide line interface. A strobe marks the timestamp point at the start of a frame. On that cycle the block latches the current seconds and nanoseconds. When the frame's header fields are later flagged as ready, it packs the held time and the header fields into one 128-bit record and writes the record into a dual-clock queue. One instance serves one direction, so transmit and receive each get their own instance.

The queue is written in the line clock and drained from the CPU clock through a four-phase request/acknowledge handshake. The read side also sees an empty flag, a fill count and a sticky overflow flag. The overflow flag marks records that were lost because the queue was full, and the CPU clears it by writing 1. Frame parsing and the time source are outside the block and arrive as plain inputs.

Top module: `ts_capture_queue`

## Requirements
- R1: After both resets, q_empty is 1, q_count is 0, rd_ack is 0, rd_data is all zeros and ovf_flag is 0.
- R2: A record is laid out as [127:112] zero, [111:64] seconds, [63:32] nanoseconds, [31:28] message type, [27:16] checksum, [15:0] sequence ID.
- R3: The time in a record is the value present on the cycle sof_mark was high. The time input changing between sof_mark and hdr_valid has no effect. A later sof_mark before hdr_valid replaces the held time.
- R4: An hdr_valid with no sof_mark since the last record (or since reset) stores nothing, and q_count does not change.
- R5: Records are read back in the order they were written, and the queue holds 2**AW records (16 by default).
- R6: rd_ack rises on the CPU clock edge after rd_req is seen high, with rd_data valid from that edge on. rd_ack stays high while rd_req is high and falls on the edge after rd_req goes low. rd_data does not change while rd_ack is high.
- R7: A read while the queue is empty returns all zeros and leaves q_count and the read position unchanged.
- R8: A record completed while the queue is full is dropped and sets ovf_flag. ovf_flag stays set until a CPU-clock cycle with ovf_clr high clears it.
- R9: q_empty and q_count reflect the stored records in the CPU domain within a few CPU cycles after a write, and q_count never exceeds 2**AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| line_clk | input | 1 | Line-side clock |
| line_rst_n | input | 1 | Active-low reset, line domain |
| sof_mark | input | 1 | Timestamp point of a qualifying frame |
| now_sec | input | 48 | Current time, seconds |
| now_ns | input | 32 | Current time, nanoseconds |
| hdr_valid | input | 1 | Header fields of the marked frame are ready |
| hdr_msg | input | 4 | Message type |
| hdr_csum | input | 12 | Checksum field |
| hdr_seq | input | 16 | Sequence ID |
| cpu_clk | input | 1 | CPU-side clock |
| cpu_rst_n | input | 1 | Active-low reset, CPU domain |
| rd_req | input | 1 | Read request (four-phase) |
| rd_ack | output | 1 | Read acknowledge |
| rd_data | output | 128 | Record returned by the last read |
| q_empty | output | 1 | Queue holds no record |
| q_count | output | AW+1 | Records stored |
| ovf_flag | output | 1 | Sticky record-dropped flag |
| ovf_clr | input | 1 | Write 1 to clear ovf_flag |

## Verification
Single frames with distinct field values show whether each field lands in its own bit range. A frame whose time input changes between the mark and the header shows whether sampling happens at the mark. A header with no preceding mark shows whether stray headers are filtered. A burst that fills the queue and then overflows it, followed by a full drain, tells FIFO ordering apart from dropping the wrong record. It also checks the capacity edge and whether the overflow flag is sticky and clearable. Reads of an empty queue, before and after data, show that an empty read neither fabricates data nor moves the read position.

// File: rtl/ts_capture_queue.sv
module ts_capture_queue #(
  parameter int AW = 4
) (
  input  logic          line_clk,
  input  logic          line_rst_n,
  input  logic          sof_mark,
  input  logic [47:0]   now_sec,
  input  logic [31:0]   now_ns,
  input  logic          hdr_valid,
  input  logic [3:0]    hdr_msg,
  input  logic [11:0]   hdr_csum,
  input  logic [15:0]   hdr_seq,
  input  logic          cpu_clk,
  input  logic          cpu_rst_n,
  input  logic          rd_req,
  output logic          rd_ack,
  output logic [127:0]  rd_data,
  output logic          q_empty,
  output logic [AW:0]   q_count,
  output logic          ovf_flag,
  input  logic          ovf_clr
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return (b >> 1) ^ b;
  endfunction

  logic [127:0] mem [DEPTH];

  // line domain
  logic          armed;
  logic [47:0]   hold_sec;
  logic [31:0]   hold_ns;
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic          drop_tgl;
  logic          full, push, wr_ok;

  assign full  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign push  = hdr_valid && armed;
  assign wr_ok = push && !full;

  always_ff @(posedge line_clk or negedge line_rst_n) begin
    if (!line_rst_n) begin
      armed <= 1'b0; hold_sec <= '0; hold_ns <= '0;
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0; drop_tgl <= 1'b0;
    end else begin
      rq1 <= rgray; rq2 <= rq1;
      if (sof_mark) begin
        armed <= 1'b1; hold_sec <= now_sec; hold_ns <= now_ns;
      end else if (push) begin
        armed <= 1'b0;
      end
      if (wr_ok) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
      if (push && full) drop_tgl <= ~drop_tgl;
    end
  end

  always_ff @(posedge line_clk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= {16'h0, hold_sec, hold_ns, hdr_msg, hdr_csum, hdr_seq};
  end

  // cpu domain
  logic [AW:0] rbin, rgray, wq1, wq2;
  logic [2:0]  dsync;

  assign q_empty = (rgray == wq2);
  assign q_count = g2b(wq2) - rbin;

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      rd_ack <= 1'b0; rd_data <= '0; dsync <= '0; ovf_flag <= 1'b0;
    end else begin
      wq1 <= wgray; wq2 <= wq1;
      dsync <= {dsync[1:0], drop_tgl};
      if (dsync[2] != dsync[1]) ovf_flag <= 1'b1;
      else if (ovf_clr)         ovf_flag <= 1'b0;
      if (rd_req && !rd_ack) begin
        rd_ack <= 1'b1;
        if (!q_empty) begin
          rd_data <= mem[rbin[AW-1:0]];
          rbin    <= rbin + 1'b1;
          rgray   <= b2g(rbin + 1'b1);
        end else begin
          rd_data <= '0;
        end
      end else if (!rd_req && rd_ack) begin
        rd_ack <= 1'b0;
      end
    end
  end

  // checks, line domain
  assert_stray_hdr_R4: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (hdr_valid && !armed && !sof_mark) |=> $stable(wgray));
  assert_no_overflow_R8: assert property (@(posedge line_clk) disable iff (!line_rst_n)
    (push && full) |=> $stable(wbin));

  // checks, cpu domain
  assert_data_stable_R6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (rd_ack && $past(rd_ack)) |-> $stable(rd_data));
  assert_ack_needs_req_R6: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    $rose(rd_ack) |-> $past(rd_req));
  assert_empty_read_R7: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    (rd_req && !rd_ack && q_empty) |=> (rd_data == '0) && $stable(rbin));
  assert_count_bound_R9: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    q_count <= (AW+1)'(DEPTH));
endmodule

// File: tb/tb_ts_capture_queue.sv
module tb_ts_capture_queue;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic line_clk = 0, cpu_clk = 0;
  logic line_rst_n = 0, cpu_rst_n = 0;
  logic sof_mark = 0, hdr_valid = 0, rd_req = 0, ovf_clr = 0;
  logic [47:0] now_sec = 0;
  logic [31:0] now_ns = 0;
  logic [3:0]  hdr_msg = 0;
  logic [11:0] hdr_csum = 0;
  logic [15:0] hdr_seq = 0;
  logic rd_ack, q_empty, ovf_flag;
  logic [127:0] rd_data;
  logic [AW:0] q_count;

  int total = 0, bad = 0;

  always #2 line_clk = ~line_clk;
  always #5 cpu_clk = ~cpu_clk;

  ts_capture_queue #(.AW(AW)) dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rec(input logic [47:0] s, input logic [31:0] n,
                                       input logic [3:0] m, input logic [11:0] c, input logic [15:0] q);
    return {16'h0, s, n, m, c, q};
  endfunction

  task automatic lcyc(input int n);
    repeat (n) @(negedge line_clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge cpu_clk);
  endtask

  task automatic mark(input logic [47:0] s, input logic [31:0] n);
    @(negedge line_clk);
    sof_mark = 1; now_sec = s; now_ns = n;
    @(negedge line_clk);
    sof_mark = 0; now_sec = ~s; now_ns = ~n;
  endtask

  task automatic hdr(input logic [3:0] m, input logic [11:0] c, input logic [15:0] q);
    @(negedge line_clk);
    hdr_valid = 1; hdr_msg = m; hdr_csum = c; hdr_seq = q;
    @(negedge line_clk);
    hdr_valid = 0;
  endtask

  task automatic cpu_read(output logic [127:0] d);
    @(negedge cpu_clk);
    rd_req = 1;
    @(negedge cpu_clk);
    chk("R6 ack one cycle after req", 128'(rd_ack), 128'(1));
    d = rd_data;
    @(negedge cpu_clk);
    chk("R6 data held under ack", rd_data, d);
    rd_req = 0;
    @(negedge cpu_clk);
    chk("R6 ack drops after req", 128'(rd_ack), 128'(0));
  endtask

  task automatic t_reset();
    chk("R1 empty", 128'(q_empty), 128'(1));
    chk("R1 count", 128'(q_count), 128'(0));
    chk("R1 ack", 128'(rd_ack), 128'(0));
    chk("R1 data", rd_data, 128'(0));
    chk("R1 ovf", 128'(ovf_flag), 128'(0));
  endtask

  task automatic t_layout();
    logic [127:0] d;
    mark(48'hA1B2_C3D4_E5F6, 32'h1234_5678);
    lcyc(3);
    hdr(4'h9, 12'hABC, 16'hBEEF);
    settle();
    chk("R9 count one", 128'(q_count), 128'(1));
    chk("R9 not empty", 128'(q_empty), 128'(0));
    cpu_read(d);
    chk("R2 record layout", d, rec(48'hA1B2_C3D4_E5F6, 32'h1234_5678, 4'h9, 12'hABC, 16'hBEEF));
    settle();
    chk("R9 empty again", 128'(q_empty), 128'(1));
  endtask

  task automatic t_hold();
    logic [127:0] d;
    mark(48'h1, 32'h100);
    mark(48'h2, 32'h200);
    @(negedge line_clk); now_sec = 48'h77; now_ns = 32'h77;
    hdr(4'h1, 12'h001, 16'h0002);
    settle();
    cpu_read(d);
    chk("R3 time from latest mark", d, rec(48'h2, 32'h200, 4'h1, 12'h001, 16'h0002));
  endtask

  task automatic t_stray();
    logic [127:0] d;
    hdr(4'h3, 12'h333, 16'h3333);
    mark(48'h5, 32'h5);
    hdr(4'h4, 12'h444, 16'h4444);
    hdr(4'h6, 12'h666, 16'h6666);
    settle();
    chk("R4 stray headers ignored", 128'(q_count), 128'(1));
    cpu_read(d);
    chk("R4 only marked frame kept", d, rec(48'h5, 32'h5, 4'h4, 12'h444, 16'h4444));
  endtask

  task automatic t_empty_read();
    logic [127:0] d;
    cpu_read(d);
    chk("R7 empty read zero", d, 128'(0));
    settle();
    chk("R7 count unchanged", 128'(q_count), 128'(0));
    mark(48'h9, 32'h9);
    hdr(4'h2, 12'h222, 16'h2222);
    settle();
    cpu_read(d);
    chk("R7 pointer not moved", d, rec(48'h9, 32'h9, 4'h2, 12'h222, 16'h2222));
  endtask

  task automatic t_overflow();
    logic [127:0] d;
    for (int i = 0; i <= DEPTH; i++) begin
      mark(48'(i + 100), 32'(i * 3));
      hdr(4'(i), 12'(i + 7), 16'(i + 1000));
    end
    settle();
    chk("R5 holds full depth", 128'(q_count), 128'(DEPTH));
    chk("R8 overflow set", 128'(ovf_flag), 128'(1));
    settle();
    chk("R8 overflow sticky", 128'(ovf_flag), 128'(1));
    @(negedge cpu_clk); ovf_clr = 1;
    @(negedge cpu_clk); ovf_clr = 0;
    chk("R8 overflow cleared", 128'(ovf_flag), 128'(0));
    for (int i = 0; i < DEPTH; i++) begin
      cpu_read(d);
      chk("R5 fifo order", d, rec(48'(i + 100), 32'(i * 3), 4'(i), 12'(i + 7), 16'(i + 1000)));
    end
    cpu_read(d);
    chk("R8 dropped record absent", d, 128'(0));
    settle();
    chk("R9 drained", 128'(q_empty), 128'(1));
  endtask

  initial begin
    repeat (3) @(negedge cpu_clk);
    line_rst_n = 1; cpu_rst_n = 1;
    settle();
    t_reset();
    t_layout();
    t_hold();
    t_stray();
    t_empty_read();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge line_clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule